// File: doc/BRIEF.md
# Floppy Head Stepper Tracker

This block sits in one expansion slot of a small computer's I/O space and listens for CPU reads in that slot's sixteen-byte switch window. Eight of the window addresses energise or release the four coils of a stepper that moves a floppy read head. The block keeps track of the head in half-track units. Each time a coil is energised, it compares the newly energised coil with the coil that was last released and moves the head one half-track inward, one half-track outward, or not at all. The position is held between 0 and a configurable maximum.

The head position is brought out as the upper part of an address into a track-data store. A byte offset within the track forms the lower part. A read of the data switch returns the store byte at that address and then advances the offset, which wraps at the track length. All the other motor, drive and write switches in the window answer with zero. Every window read is answered one cycle later on a registered data port with a valid strobe.

Top module: `floppy_head_ctl`

## Requirements
- R1: After synchronous reset, the half-track position is POS_MAX (80 by default), the byte offset is 0, both coil registers hold 0 and `rd_valid` is low.
- R2: Only reads whose address lies in IO_BASE + 16*SLOT up to that value + 15 (0xC0E0..0xC0EF for the defaults) have any effect. Any other read leaves position and offset unchanged and produces no `rd_valid`.
- R3: A read at window offset 1, 3, 5 or 7 energises coil offset/2. That coil becomes the current coil. The position then changes by +1 when (new coil - last coil) mod 4 = 1, by -1 when it is 3, and by 0 otherwise.
- R4: A read at window offset 0, 2, 4 or 6 copies the current coil into the last-coil register, whatever coil index the offset names, and leaves the position unchanged.
- R5: The position never goes below 0 or above POS_MAX. A step that would leave this range leaves the position at the limit.
- R6: Window reads at offsets 8..15 other than 12 return `rd_data` = 0 with `rd_valid` high in the following cycle. They change neither position nor offset. Coil offsets 0..7 also answer 0.
- R7: A read at window offset 12 returns, in the following cycle, the `trk_byte` value presented while `trk_half` and `trk_ofs` showed the position and offset in effect at the access.
- R8: Each offset-12 read advances `trk_ofs` by one. After TRK_BYTES-1 it wraps to 0. No other access changes it.
- R9: A change of head position does not reset or alter the byte offset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rd | input | 1 | CPU read strobe, one cycle per access |
| bus_addr | input | ADDR_W | CPU address |
| rd_valid | output | 1 | Registered: a window read was answered |
| rd_data | output | 8 | Registered read data |
| trk_half | output | POS_W | Head position in half-tracks; upper part of track-store address |
| trk_ofs | output | clog2(TRK_BYTES) | Byte offset within the track; lower part of track-store address |
| trk_byte | input | 8 | Track-store byte for the presented address, same cycle |

## Verification
On every cycle the assertions check the following:
- the position stays in range and moves by at most one half-track;
- the position is held on any access other than a coil-on;
- the offset moves only on data reads and stays below the track length;
- accesses outside the window go unanswered;
- the non-data switches answer zero;
- a data read returns the byte that was presented.

The direction of each step comes from the coil-pair rule, and it depends on the history of releases. Only the bench's scenarios show it. These scenarios include the following:
- stepping with and without an intervening release;
- walking the head to each clamp;
- wrapping the offset across a head move.

// File: rtl/fhc_pkg.sv
package fhc_pkg;

  typedef logic [1:0] coil_t;

  typedef enum logic [1:0] {
    MV_HOLD = 2'd0,
    MV_INC  = 2'd1,
    MV_DEC  = 2'd2
  } move_e;

  typedef struct packed {
    logic  any_hit;
    logic  coil_on;
    logic  coil_off;
    coil_t coil_idx;
    logic  data_rd;
  } sw_cmd_t;

  localparam logic [3:0] SW_DATA_OFS = 4'hC;

  // Step direction from the newly energised coil relative to the last released one.
  function automatic move_e coil_move(coil_t now_c, coil_t prev_c);
    coil_t diff;
    diff = now_c - prev_c;
    case (diff)
      2'd1:    return MV_INC;
      2'd3:    return MV_DEC;
      default: return MV_HOLD;
    endcase
  endfunction

endpackage

// File: rtl/fhc_decode.sv
module fhc_decode
  import fhc_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int IO_BASE = 16'hC080,
  parameter int SLOT    = 6
) (
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  output sw_cmd_t           cmd
);
  localparam logic [ADDR_W-1:0] WIN_BASE = ADDR_W'(IO_BASE + 16 * SLOT);

  logic       hit;
  logic [3:0] ofs;

  assign hit = bus_rd && (bus_addr[ADDR_W-1:4] == WIN_BASE[ADDR_W-1:4]);
  assign ofs = bus_addr[3:0];

  always_comb begin
    cmd.any_hit  = hit;
    cmd.coil_on  = hit && !ofs[3] && ofs[0];
    cmd.coil_off = hit && !ofs[3] && !ofs[0];
    cmd.coil_idx = ofs[2:1];
    cmd.data_rd  = hit && (ofs == SW_DATA_OFS);
  end

endmodule

// File: rtl/fhc_stepper.sv
module fhc_stepper
  import fhc_pkg::*;
#(
  parameter int POS_W   = 7,
  parameter int POS_MAX = 80
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             coil_on,
  input  logic             coil_off,
  input  coil_t            coil_idx,
  output logic [POS_W-1:0] pos
);
  localparam logic [POS_W-1:0] POS_TOP = POS_W'(POS_MAX);

  coil_t            cur_q;
  coil_t            last_q;
  logic [POS_W-1:0] pos_q;
  logic [POS_W-1:0] pos_nxt;
  move_e            mv;

  assign mv = coil_move(coil_idx, last_q);

  always_comb begin
    pos_nxt = pos_q;
    case (mv)
      MV_INC:  pos_nxt = (pos_q >= POS_TOP) ? POS_TOP : pos_q + 1'b1;
      MV_DEC:  pos_nxt = (pos_q == '0) ? '0 : pos_q - 1'b1;
      default: pos_nxt = pos_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q  <= '0;
      last_q <= '0;
      pos_q  <= POS_TOP;
    end else if (coil_on) begin
      cur_q <= coil_idx;
      pos_q <= pos_nxt;
    end else if (coil_off) begin
      last_q <= cur_q;
    end
  end

  assign pos = pos_q;

endmodule

// File: rtl/fhc_track_reader.sv
module fhc_track_reader #(
  parameter int TRK_BYTES = 6656,
  parameter int OFS_W     = $clog2(TRK_BYTES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             any_hit,
  input  logic             data_rd,
  input  logic [7:0]       trk_byte,
  output logic [OFS_W-1:0] trk_ofs,
  output logic             rd_valid,
  output logic [7:0]       rd_data
);
  localparam logic [OFS_W-1:0] OFS_LAST = OFS_W'(TRK_BYTES - 1);

  logic [OFS_W-1:0] ofs_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ofs_q    <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= any_hit;
      rd_data  <= data_rd ? trk_byte : 8'h00;
      if (data_rd) ofs_q <= (ofs_q == OFS_LAST) ? '0 : ofs_q + 1'b1;
    end
  end

  assign trk_ofs = ofs_q;

endmodule

// File: rtl/floppy_head_ctl.sv
module floppy_head_ctl
  import fhc_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int IO_BASE   = 16'hC080,
  parameter int SLOT      = 6,
  parameter int POS_W     = 7,
  parameter int POS_MAX   = 80,
  parameter int TRK_BYTES = 6656
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         bus_rd,
  input  logic [ADDR_W-1:0]            bus_addr,
  output logic                         rd_valid,
  output logic [7:0]                   rd_data,
  output logic [POS_W-1:0]             trk_half,
  output logic [$clog2(TRK_BYTES)-1:0] trk_ofs,
  input  logic [7:0]                   trk_byte
);
  localparam int OFS_W = $clog2(TRK_BYTES);

  sw_cmd_t cmd;

  fhc_decode #(
    .ADDR_W (ADDR_W),
    .IO_BASE(IO_BASE),
    .SLOT   (SLOT)
  ) decode_i (
    .bus_rd  (bus_rd),
    .bus_addr(bus_addr),
    .cmd     (cmd)
  );

  fhc_stepper #(
    .POS_W  (POS_W),
    .POS_MAX(POS_MAX)
  ) stepper_i (
    .clk     (clk),
    .rst     (rst),
    .coil_on (cmd.coil_on),
    .coil_off(cmd.coil_off),
    .coil_idx(cmd.coil_idx),
    .pos     (trk_half)
  );

  fhc_track_reader #(
    .TRK_BYTES(TRK_BYTES),
    .OFS_W    (OFS_W)
  ) reader_i (
    .clk     (clk),
    .rst     (rst),
    .any_hit (cmd.any_hit),
    .data_rd (cmd.data_rd),
    .trk_byte(trk_byte),
    .trk_ofs (trk_ofs),
    .rd_valid(rd_valid),
    .rd_data (rd_data)
  );

endmodule

// File: rtl/floppy_head_chk.sv
module floppy_head_chk #(
  parameter int ADDR_W    = 16,
  parameter int IO_BASE   = 16'hC080,
  parameter int SLOT      = 6,
  parameter int POS_W     = 7,
  parameter int POS_MAX   = 80,
  parameter int TRK_BYTES = 6656
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         bus_rd,
  input logic [ADDR_W-1:0]            bus_addr,
  input logic                         rd_valid,
  input logic [7:0]                   rd_data,
  input logic [POS_W-1:0]             trk_half,
  input logic [$clog2(TRK_BYTES)-1:0] trk_ofs,
  input logic [7:0]                   trk_byte
);
  localparam logic [ADDR_W-1:0] WBASE = ADDR_W'(IO_BASE + 16 * SLOT);

  logic in_win, on_acc, data_acc, zero_acc;
  assign in_win   = bus_rd && (bus_addr[ADDR_W-1:4] == WBASE[ADDR_W-1:4]);
  assign on_acc   = in_win && (bus_addr[3] == 1'b0) && bus_addr[0];
  assign data_acc = in_win && (bus_addr[3:0] == 4'hC);
  assign zero_acc = in_win && (bus_addr[3:0] != 4'hC);

  AST_POS_RANGE: assert property (@(posedge clk) disable iff (rst)
    trk_half <= POS_W'(POS_MAX)); // R5
  AST_POS_STEP: assert property (@(posedge clk) disable iff (rst)
    (trk_half != $past(trk_half)) |->
      ((trk_half == $past(trk_half) + 1'b1) || ($past(trk_half) == trk_half + 1'b1))); // R3
  AST_POS_HOLD: assert property (@(posedge clk) disable iff (rst)
    !on_acc |=> $stable(trk_half)); // R4
  AST_OFS_HOLD: assert property (@(posedge clk) disable iff (rst)
    !data_acc |=> $stable(trk_ofs)); // R8
  AST_OFS_RANGE: assert property (@(posedge clk) disable iff (rst)
    int'(trk_ofs) < TRK_BYTES); // R8
  AST_NO_ANSWER: assert property (@(posedge clk) disable iff (rst)
    !in_win |=> !rd_valid); // R2
  AST_ZERO_ANSWER: assert property (@(posedge clk) disable iff (rst)
    zero_acc |=> (rd_valid && (rd_data == 8'h00))); // R6
  AST_DATA_ANSWER: assert property (@(posedge clk) disable iff (rst)
    data_acc |=> (rd_valid && (rd_data == $past(trk_byte)))); // R7

endmodule

bind floppy_head_ctl floppy_head_chk #(
  .ADDR_W   (ADDR_W),
  .IO_BASE  (IO_BASE),
  .SLOT     (SLOT),
  .POS_W    (POS_W),
  .POS_MAX  (POS_MAX),
  .TRK_BYTES(TRK_BYTES)
) chk_i (
  .clk     (clk),
  .rst     (rst),
  .bus_rd  (bus_rd),
  .bus_addr(bus_addr),
  .rd_valid(rd_valid),
  .rd_data (rd_data),
  .trk_half(trk_half),
  .trk_ofs (trk_ofs),
  .trk_byte(trk_byte)
);

// File: tb/floppy_head_ctl_tb_top.sv
`timescale 1ns/1ps
module floppy_head_ctl_tb_top;
  localparam int NBYTES = 5;
  localparam int PMAX   = 80;
  localparam logic [15:0] WIN = 16'hC0E0;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_rd = 1'b0;
  logic [15:0] bus_addr = 16'h0000;
  logic        rd_valid;
  logic [7:0]  rd_data;
  logic [6:0]  trk_half;
  logic [2:0]  trk_ofs;
  logic [7:0]  trk_byte;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench-side model state
  int m_pos = PMAX, m_cur = 0, m_last = 0, m_ofs = 0;
  logic [7:0] exp_q[$];
  string      req_q[$];

  always #10 clk = ~clk;

  function automatic logic [7:0] mem_f(int h, int o);
    return 8'((h * 7) ^ (o * 29) ^ 8'hA5);
  endfunction

  assign trk_byte = mem_f(int'(trk_half), int'(trk_ofs));

  floppy_head_ctl #(.SLOT(6), .TRK_BYTES(NBYTES)) dut_i (
    .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .rd_valid(rd_valid), .rd_data(rd_data), .trk_half(trk_half),
    .trk_ofs(trk_ofs), .trk_byte(trk_byte)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // driver: one read access, model update, expectation pushed to the scoreboard
  task automatic access(logic [15:0] a, string req);
    int o, d;
    bus_addr = a;
    bus_rd   = 1'b1;
    if (a[15:4] == WIN[15:4]) begin
      o = int'(a[3:0]);
      if (o == 12) begin
        exp_q.push_back(mem_f(m_pos, m_ofs));
        m_ofs = (m_ofs + 1) % NBYTES;
      end else begin
        exp_q.push_back(8'h00);
        if (o < 8) begin
          if (o % 2 == 1) begin
            m_cur = o / 2;
            d = (m_cur - m_last + 4) % 4;
            if (d == 1 && m_pos < PMAX) m_pos++;
            if (d == 3 && m_pos > 0) m_pos--;
          end else begin
            m_last = m_cur;
          end
        end
      end
      req_q.push_back(req);
    end
    @(negedge clk);
    bus_rd = 1'b0;
    chk(req, "trk_half", int'(trk_half), m_pos);
    chk(req, "trk_ofs", int'(trk_ofs), m_ofs);
  endtask

  // release (through any off offset), then energise the neighbour coil
  task automatic step(int dir, string req);
    access(WIN | 16'(2 * ((m_cur + 2) % 4)), "R4");
    access(WIN | 16'(2 * ((m_cur + dir + 4) % 4) + 1), req);
  endtask

  // monitor: pops the scoreboard whenever an answer appears
  always @(negedge clk) begin
    if (!rst && !done && rd_valid) begin
      if (exp_q.size() == 0) begin
        checks++;
        errors++;
        $display("FAIL R2 unexpected answer: actual %0d expected none", rd_data);
      end else begin
        logic [7:0] e;
        string r;
        e = exp_q.pop_front();
        r = req_q.pop_front();
        chk(r, "rd_data", int'(rd_data), int'(e));
      end
    end
  end

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1", "trk_half", int'(trk_half), PMAX);
    chk("R1", "trk_ofs", int'(trk_ofs), 0);
    chk("R1", "rd_valid", int'(rd_valid), 0);

    // R7 R8 data reads with wrap
    for (int i = 0; i < 7; i++) access(WIN | 16'hC, "R7");
    // R6 other switches answer zero
    for (int i = 8; i < 16; i++) if (i != 12) access(WIN | 16'(i), "R6");
    // R2 outside the window
    access(16'hC08C, "R2");
    access(16'hC0FC, "R2");
    access(16'hC0D1, "R2");
    access(16'h00EC, "R2");
    access(16'hC0F3, "R2");

    // R5 step up at the top clamps
    access(WIN | 16'h3, "R5");
    step(1, "R5");
    // R3 energise without release: last still stale
    access(WIN | 16'h5, "R3");
    access(WIN | 16'h5, "R3");
    // R3 opposite coil and same coil after release
    step(2, "R3");
    step(0, "R3");
    // walk down to bottom clamp, reads interleaved (R9)
    for (int i = 0; i < 86; i++) begin
      step(-1, "R3");
      if (i % 20 == 3) access(WIN | 16'hC, "R9");
    end
    chk("R5", "bottom", int'(trk_half), 0);
    step(-1, "R5");
    for (int i = 0; i < 3; i++) step(1, "R3");
    access(WIN | 16'hC, "R9");
    access(WIN | 16'hC, "R8");
    access(WIN | 16'hC, "R8");

    repeat (3) @(negedge clk);
    chk("R2", "pending answers", exp_q.size(), 0);
    finish_run();
  end

endmodule